// File: doc/BRIEF.md
# Latency-Matching Delay Line for Timed Converter Channels

Several timed update channels often feed one digital-to-analog converter channel through datapaths of unequal depth. One example is a pair of rotation-based phase generators beside a single polynomial interpolator. Updates that carry the same timestamp would then reach the converter on different cycles. This block sits on the data side, after the timed-event interface. It holds back one channel's update word and its valid strobe by a selectable number of cycles, so that all channels land on the converter in the same cycle. Timestamps are not offset.

The 38-bit update word is treated as two 19-bit lanes. Each lane is a 16-bit value with 3 guard bits. The word travels through shift storage that has no reset, built from chained segments of at most 32 stages each. The strobe travels separately through resettable flip-flops. A final output register loads the word only when the delayed strobe is high. Stale contents of the resetless storage therefore never reach the output after a reset. The delay is chosen per instance through a configuration input that is changed only while the channel is idle.

Top module: `latmatch_delay`

## Requirements
- R1: With effective delay N (1 to 40), a high `in_valid` in the cycle ending at clock edge t makes `out_valid` high after edge t+N, for exactly one cycle per input strobe.
- R2: The `out_data` shown with each `out_valid` pulse equals the `in_data` presented with the matching input strobe, both 19-bit lanes (bits 37:19 and 18:0) unchanged.
- R3: While `out_valid` is low, `out_data` keeps its last loaded value; `in_data` presented without `in_valid` never reaches the output.
- R4: Synchronous active-high `rst` clears `out_valid` and `out_data` to zero and discards strobes in flight; after reset no `out_valid` appears until a new input strobe has travelled the full delay, whatever the resetless storage still holds.
- R5: `delay_cfg` value 0 acts as delay 1, and values above 40 act as delay 40.
- R6: Delays longer than one 32-stage storage segment (33 to 40) keep exact latency and data across the segment boundary.
- R7: Strobes on every consecutive cycle (full rate) all emerge in order, each with its own word, with no loss or merging.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the strobe path and output register |
| in_valid | input | 1 | Update strobe from the timed-event interface |
| in_data | input | 38 | Update word, lane A in bits 37:19, lane B in bits 18:0 |
| delay_cfg | input | 6 | Delay in cycles, clamped to 1..40 |
| out_valid | output | 1 | Delayed update strobe |
| out_data | output | 38 | Delayed update word, held between strobes |

## Verification
The latency and data properties assume that `delay_cfg` does not change while strobes are in flight. They are checked only once the setting has been stable for at least the selected delay, because the output during a change is not defined. The stimulus changes the setting only after more than 40 idle cycles and keeps it fixed through every burst. It also drives varying junk on `in_data` while `in_valid` is low, so that the hold property sees real attempts to disturb the output.

// File: rtl/latmatch_pkg.sv
package latmatch_pkg;

    localparam int LANE_W        = 19;
    localparam int SAMPLE_W      = 2 * LANE_W;
    localparam int MAX_DELAY_DEF = 40;
    localparam int SEG_DEPTH_DEF = 32;

    typedef struct packed {
        logic [LANE_W-1:0] lane_a;
        logic [LANE_W-1:0] lane_b;
    } lane_pair_t;

    // Map a raw setting onto the legal range 1..max_d.
    function automatic int clamp_delay(input int cfg, input int max_d);
        if (cfg < 1)
            return 1;
        if (cfg > max_d)
            return max_d;
        return cfg;
    endfunction

    // Stage count of storage segment idx when total stages are split in chunks of seg.
    function automatic int seg_len(input int idx, input int total, input int seg);
        int rem;
        rem = total - idx * seg;
        return (rem < seg) ? rem : seg;
    endfunction

endpackage

// File: rtl/lat_data_seg.sv
module lat_data_seg
    import latmatch_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                            clk,
    input  logic [SAMPLE_W-1:0]             din,
    output logic [DEPTH-1:0][SAMPLE_W-1:0]  taps
);

    // Resetless shift storage; taps[k] is din delayed by k+1 cycles.
    logic [DEPTH-1:0][SAMPLE_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        stage_q[0] <= din;
        for (int k = 1; k < DEPTH; k++) begin
            stage_q[k] <= stage_q[k-1];
        end
    end

    assign taps = stage_q;

endmodule

// File: rtl/lat_strobe_line.sv
module lat_strobe_line #(
    parameter int STAGES = 39
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    output logic [STAGES-1:0] taps
);

    // Resettable strobe flops; taps[k] is din delayed by k+1 cycles.
    logic [STAGES-1:0] bit_q;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_bit
            if (k == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) bit_q[k] <= 1'b0;
                    else     bit_q[k] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) bit_q[k] <= 1'b0;
                    else     bit_q[k] <= bit_q[k-1];
                end
            end
        end
    endgenerate

    assign taps = bit_q;

endmodule

// File: rtl/lat_tap_select.sv
module lat_tap_select
    import latmatch_pkg::*;
#(
    parameter int MAX_DELAY = 40,
    parameter int CFG_W     = 6
) (
    input  logic [CFG_W-1:0]                    delay_cfg,
    input  logic [MAX_DELAY-1:0][SAMPLE_W-1:0]  data_taps,
    input  logic [MAX_DELAY-1:0]                valid_taps,
    output logic [SAMPLE_W-1:0]                 sel_data,
    output logic                                sel_valid
);

    // Tap k carries the input delayed by k cycles; the output register adds one more.
    int tap_idx;

    always_comb begin
        tap_idx   = clamp_delay(int'(delay_cfg), MAX_DELAY) - 1;
        sel_data  = data_taps[tap_idx];
        sel_valid = valid_taps[tap_idx];
    end

endmodule

// File: rtl/latmatch_delay.sv
module latmatch_delay
    import latmatch_pkg::*;
#(
    parameter int MAX_DELAY = MAX_DELAY_DEF,
    parameter int SEG_DEPTH = SEG_DEPTH_DEF,
    localparam int CFG_W    = $clog2(MAX_DELAY + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [SAMPLE_W-1:0]  in_data,
    input  logic [CFG_W-1:0]     delay_cfg,
    output logic                 out_valid,
    output logic [SAMPLE_W-1:0]  out_data
);

    localparam int STAGES = MAX_DELAY - 1;
    localparam int NSEG   = (STAGES + SEG_DEPTH - 1) / SEG_DEPTH;

    logic [MAX_DELAY-1:0][SAMPLE_W-1:0] data_taps;
    logic [MAX_DELAY-1:0]               valid_taps;
    logic [SAMPLE_W-1:0]                sel_data;
    logic                               sel_valid;
    lane_pair_t                         out_q;
    logic                               valid_q;

    assign data_taps[0]  = in_data;
    assign valid_taps[0] = in_valid;

    generate
        if (STAGES > 0) begin : g_delay
            // Data: chained resetless segments, each fed by the last tap of the one before.
            for (genvar s = 0; s < NSEG; s++) begin : g_seg
                localparam int LEN = seg_len(s, STAGES, SEG_DEPTH);
                logic [LEN-1:0][SAMPLE_W-1:0] seg_taps;

                lat_data_seg #(.DEPTH(LEN)) u_seg (
                    .clk  (clk),
                    .din  (data_taps[s*SEG_DEPTH]),
                    .taps (seg_taps)
                );

                for (genvar k = 0; k < LEN; k++) begin : g_tap
                    assign data_taps[s*SEG_DEPTH + 1 + k] = seg_taps[k];
                end
            end

            // Strobe: one resettable flop chain of the same length.
            logic [STAGES-1:0] strobe_taps;

            lat_strobe_line #(.STAGES(STAGES)) u_strobe (
                .clk  (clk),
                .rst  (rst),
                .din  (in_valid),
                .taps (strobe_taps)
            );

            assign valid_taps[MAX_DELAY-1:1] = strobe_taps;
        end
    endgenerate

    lat_tap_select #(
        .MAX_DELAY (MAX_DELAY),
        .CFG_W     (CFG_W)
    ) u_sel (
        .delay_cfg  (delay_cfg),
        .data_taps  (data_taps),
        .valid_taps (valid_taps),
        .sel_data   (sel_data),
        .sel_valid  (sel_valid)
    );

    // Output register: loads only on the delayed strobe, so stale storage stays hidden.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            out_q   <= '0;
        end else begin
            valid_q <= sel_valid;
            if (sel_valid) begin
                out_q <= lane_pair_t'(sel_data);
            end
        end
    end

    assign out_valid = valid_q;
    assign out_data  = out_q;

endmodule

// File: rtl/lat_checker.sv
module lat_checker
    import latmatch_pkg::*;
#(
    parameter int MAX_DELAY = 40,
    parameter int CFG_W     = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [SAMPLE_W-1:0]  in_data,
    input logic [CFG_W-1:0]     delay_cfg,
    input logic                 out_valid,
    input logic [SAMPLE_W-1:0]  out_data
);

    logic [MAX_DELAY:1]  hist_v;
    logic [SAMPLE_W-1:0] hist_d [1:MAX_DELAY];
    logic [CFG_W-1:0]    cfg_prev;
    int                  cfg_age;
    int                  eff;

    always_comb eff = clamp_delay(int'(delay_cfg), MAX_DELAY);

    always_ff @(posedge clk) begin
        if (rst) hist_v <= '0;
        else     hist_v <= {hist_v[MAX_DELAY-1:1], in_valid};
    end

    always_ff @(posedge clk) begin
        hist_d[1] <= in_data;
        for (int k = 2; k <= MAX_DELAY; k++) begin
            hist_d[k] <= hist_d[k-1];
        end
    end

    always_ff @(posedge clk) begin
        cfg_prev <= delay_cfg;
        if (rst || (delay_cfg != cfg_prev)) cfg_age <= 0;
        else if (cfg_age < MAX_DELAY)       cfg_age <= cfg_age + 1;
    end

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cfg_age >= eff) |-> (out_valid == hist_v[eff])); // R1

    AST_DATA_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cfg_age >= eff && out_valid) |-> (out_data == hist_d[eff])); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data)); // R3

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0)); // R4

endmodule

bind latmatch_delay lat_checker #(
    .MAX_DELAY (MAX_DELAY),
    .CFG_W     (CFG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .delay_cfg (delay_cfg),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/latmatch_delay_test.sv
module latmatch_delay_test;

    localparam int W    = 38;
    localparam int MAXD = 40;
    localparam int CW   = 6;

    logic          clk       = 1'b0;
    logic          rst       = 1'b1;
    logic          in_valid  = 1'b0;
    logic [W-1:0]  in_data   = '0;
    logic [CW-1:0] delay_cfg = CW'(1);
    logic          out_valid;
    logic [W-1:0]  out_data;

    latmatch_delay uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .delay_cfg (delay_cfg),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int           due;
        logic [W-1:0] word;
    } item_t;

    item_t        sb_q[$];
    int           n_cmp  = 0;
    int           n_bad  = 0;
    logic [W-1:0] hold_exp = '0;
    string        cur_tag = "R1";
    bit           done   = 1'b0;

    // Expected delay from the requirement text: 0 -> 1, above 40 -> 40.
    function automatic int exp_delay(input int cfg);
        if (cfg == 0)   return 1;
        if (cfg > MAXD) return MAXD;
        return cfg;
    endfunction

    function automatic logic [W-1:0] pattern(input int k);
        logic [18:0] a;
        logic [18:0] b;
        a = 19'(k * 37 + 5);
        b = 19'(k) ^ 19'h5A5A5;
        return {a, b};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (%s) at cycle %0d: actual %0h expected %0h", req, cur_tag, cyc, act, exp);
        end
    endtask

    // Monitor: sample well after the active edge.
    always @(posedge clk) begin
        #3;
        if (rst) begin
            sb_q.delete();
            hold_exp = '0;
        end else if (out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R4", 1, 0); // strobe with nothing in flight
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.due == cyc, "R1", cyc, it.due);
                check(out_data == it.word, "R2", out_data, it.word);
                hold_exp = out_data;
            end
        end else begin
            check(out_data == hold_exp, "R3", out_data, hold_exp);
            if (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                check(1'b0, "R1", 0, sb_q[0].due);
                void'(sb_q.pop_front());
            end
        end
    end

    // Driver: one cycle per call, pushes the expected arrival when valid.
    task automatic drive(input bit v, input logic [W-1:0] d);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        if (v) sb_q.push_back('{cyc + exp_delay(int'(delay_cfg)), d});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, ~pattern(i + 900));
    endtask

    task automatic set_cfg(input int c);
        idle(MAXD + 5);
        @(negedge clk);
        delay_cfg = CW'(c);
        idle(3);
    endtask

    task automatic traffic(input int seed);
        // sparse strobes with junk between them
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, pattern(seed + i));
            idle(i + 1);
        end
        // full-rate burst
        cur_tag = "R7";
        for (int i = 0; i < 10; i++) drive(1'b1, pattern(seed + 100 + i));
        idle(2);
        drive(1'b1, pattern(seed + 200));
        drive(1'b1, pattern(seed + 201));
        idle(1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #3;
        check(out_valid == 1'b0, "R4", out_valid, 0);
        check(out_data == '0, "R4", out_data, 0);

        for (int j = 0; j < 4; j++) begin
            int dl;
            dl = (j == 0) ? 1 : (j == 1) ? 2 : (j == 2) ? 7 : 32;
            cur_tag = "R1";
            set_cfg(dl);
            traffic(j * 1000);
        end

        for (int j = 0; j < 3; j++) begin
            int dl;
            dl = (j == 0) ? 33 : (j == 1) ? 39 : 40;
            cur_tag = "R6";
            set_cfg(dl);
            traffic(5000 + j * 1000);
        end

        cur_tag = "R5";
        set_cfg(0);
        traffic(9000);
        cur_tag = "R5";
        set_cfg(50);
        traffic(10000);

        // Reset with strobes in flight: nothing may emerge afterwards.
        cur_tag = "R4";
        set_cfg(40);
        for (int i = 0; i < 20; i++) drive(1'b1, pattern(20000 + i));
        idle(5);
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        @(negedge clk);
        rst = 1'b0;
        idle(MAXD + 10);
        check(out_valid == 1'b0 && out_data == '0, "R4", out_data, 0);

        // Normal service resumes after the reset.
        cur_tag = "R2";
        traffic(30000);
        idle(MAXD + 10);
        check(sb_q.size() == 0, "R1", sb_q.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule